// File: doc/BRIEF.md
# Split Arithmetic/Logic Unit

This block is a purely combinational N-bit ALU. It takes two N-bit operands and a 3-bit operation code and returns one N-bit result. The most significant code bit picks one of two separate units. An arithmetic unit is built as a single chain of full adders, and a logical unit is built as a row of identical bit cells. A final 2:1 multiplexer joins the two unit outputs into the result.

The arithmetic unit never switches between an adder and a subtractor. It rewrites the operands on their way into the adder chain instead. Per bit, the A side can pass or invert, and the B side can pass, invert or be forced to zero. A single carry-in bit completes the operation. This lets one chain serve four operations: addition, subtraction, negation and increment. All arithmetic is modulo 2^N, and the carry leaving the top bit is discarded.

A small control decoder turns the operation code into a struct of strobes. The datapath consumes only that struct, so the code assignment stays in one place.

Top module: `split_alu`

## Requirements
- R1: With opCode = 3'b000 the result equals (opA + opB) mod 2^WIDTH.
- R2: With opCode = 3'b001 the result equals (opA - opB) mod 2^WIDTH, that is opA plus the inverse of opB plus one.
- R3: With opCode = 3'b010 the result equals the two's complement negation of opA, mod 2^WIDTH. opB has no effect.
- R4: With opCode = 3'b011 the result equals (opA + 1) mod 2^WIDTH. opB has no effect.
- R5: With opCode = 3'b100 the result equals the bitwise AND of opA and opB.
- R6: With opCode = 3'b101 the result equals the bitwise OR of opA and opB.
- R7: With opCode = 3'b110 the result equals the bitwise XOR of opA and opB.
- R8: With opCode = 3'b111 the result equals the bitwise inverse of opA. opB has no effect.
- R9: A carry out of the most significant bit is dropped. For example, all-ones plus one gives zero, and all-ones plus all-ones gives all-ones minus one.
- R10: opCode[2] alone selects the unit, arithmetic when 0 and logical when 1. opCode[1:0] selects the operation within that unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| opCode | input | 3 | Operation code: bit 2 selects the unit, bits 1:0 select the operation |
| result | output | WIDTH | Combinational result |

## Verification
The bench builds two copies of the block, one at the default WIDTH of 8 and one at WIDTH 4. At WIDTH 4 every opcode is driven with every operand pair, so every carry path through the narrow chain, and every wrap-around of subtraction, negation and increment, is covered exhaustively. The 8-bit copy receives corner operands (zero, all ones, the most negative value, the most positive value, one) in every pairing, plus random operands. It also receives pairs that differ only in opB, which show that opB has no effect in the operations that ignore it.

// File: rtl/alu_pkg.sv
package alu_pkg;

  // Operation code layout: bit 2 picks the unit, bits 1:0 pick the operation.
  localparam int OPCODE_W = 3;

  typedef enum logic [1:0] {
    LOG_AND  = 2'b00,
    LOG_OR   = 2'b01,
    LOG_XOR  = 2'b10,
    LOG_NOTA = 2'b11
  } logicOp_e;

  typedef enum logic [1:0] {
    ARI_ADD = 2'b00,
    ARI_SUB = 2'b01,
    ARI_NEG = 2'b10,
    ARI_INC = 2'b11
  } arithOp_e;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic     useArith;  // 1: arithmetic unit drives the result
    logic     invA;      // invert A before the adder
    logic     invB;      // invert B before the adder
    logic     zeroB;     // force B side of the adder to zero
    logic     carryIn;   // carry into bit 0 of the chain
    logicOp_e logicSel;  // bitwise function of the logical unit
  } aluStrobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [OPCODE_W-1:0] opCode,
  output aluStrobe_t          strb
);

  arithOp_e ariOp;

  always_comb begin
    ariOp         = arithOp_e'(opCode[1:0]);
    strb.useArith = ~opCode[2];
    strb.logicSel = logicOp_e'(opCode[1:0]);
    strb.invA     = 1'b0;
    strb.invB     = 1'b0;
    strb.zeroB    = 1'b0;
    strb.carryIn  = 1'b0;
    unique case (ariOp)
      ARI_ADD: begin
        strb.carryIn = 1'b0;
      end
      ARI_SUB: begin
        strb.invB    = 1'b1;
        strb.carryIn = 1'b1;
      end
      ARI_NEG: begin
        strb.invA    = 1'b1;
        strb.zeroB   = 1'b1;
        strb.carryIn = 1'b1;
      end
      ARI_INC: begin
        strb.zeroB   = 1'b1;
        strb.carryIn = 1'b1;
      end
      default: begin
        strb.carryIn = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu_bit_cells.sv
// Per-bit leaf cells of the datapath.

// Operand conditioning for one bit: optional zeroing, then optional inversion.
module alu_operand_cond (
  input  logic inBit,
  input  logic invert,
  input  logic force0,
  output logic outBit
);
  always_comb begin
    if (force0) outBit = 1'b0;
    else        outBit = inBit ^ invert;
  end
endmodule

// One full adder stage of the ripple chain.
module alu_full_adder (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);
  logic halfSum;
  always_comb begin
    halfSum = x ^ y;
    s       = halfSum ^ cin;
    cout    = (x & y) | (halfSum & cin);
  end
endmodule

// Top stage of the chain: sum only, since the top carry is dropped.
module alu_sum_cell (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s
);
  always_comb s = x ^ y ^ cin;
endmodule

// One bit of the logical unit.
module alu_logic_cell
  import alu_pkg::*;
(
  input  logicOp_e sel,
  input  logic     aBit,
  input  logic     bBit,
  output logic     gBit
);
  always_comb begin
    unique case (sel)
      LOG_AND:  gBit = aBit & bBit;
      LOG_OR:   gBit = aBit | bBit;
      LOG_XOR:  gBit = aBit ^ bBit;
      LOG_NOTA: gBit = ~aBit;
      default:  gBit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  aluStrobe_t       strb,
  output logic [WIDTH-1:0] f
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] condA;
  logic [WIDTH-1:0] condB;
  logic [WIDTH-1:0] arithOut;   // H
  logic [WIDTH-1:0] logicOut;   // G
  logic [WIDTH-1:0] carry;      // carry into each bit

  assign carry[0] = strb.carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    alu_operand_cond uCondA (
      .inBit (a[i]),
      .invert(strb.invA),
      .force0(1'b0),
      .outBit(condA[i])
    );

    alu_operand_cond uCondB (
      .inBit (b[i]),
      .invert(strb.invB),
      .force0(strb.zeroB),
      .outBit(condB[i])
    );

    if (i < TOP) begin : gChain
      alu_full_adder uFa (
        .x   (condA[i]),
        .y   (condB[i]),
        .cin (carry[i]),
        .s   (arithOut[i]),
        .cout(carry[i+1])
      );
    end else begin : gTop
      alu_sum_cell uSum (
        .x  (condA[i]),
        .y  (condB[i]),
        .cin(carry[i]),
        .s  (arithOut[i])
      );
    end

    alu_logic_cell uLog (
      .sel (strb.logicSel),
      .aBit(a[i]),
      .bBit(b[i]),
      .gBit(logicOut[i])
    );
  end

  // Final 2:1 merge of the two units.
  assign f = strb.useArith ? arithOut : logicOut;

endmodule

// File: rtl/split_alu.sv
module split_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]    opA,
  input  logic [WIDTH-1:0]    opB,
  input  logic [OPCODE_W-1:0] opCode,
  output logic [WIDTH-1:0]    result
);

  aluStrobe_t strb;

  alu_ctrl uCtrl (
    .opCode(opCode),
    .strb  (strb)
  );

  alu_datapath #(.WIDTH(WIDTH)) uPath (
    .a   (opA),
    .b   (opB),
    .strb(strb),
    .f   (result)
  );

endmodule

// File: rtl/split_alu_chk.sv
module split_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       opCode,
  input logic [WIDTH-1:0] result
);

  always_comb begin
    case (opCode)
      3'b000: begin
        // R1 R9
        add_chk: assert (result == WIDTH'(opA + opB)) else $error("add mismatch");
      end
      3'b001: begin
        // R2
        sub_chk: assert (result == WIDTH'(opA - opB)) else $error("sub mismatch");
      end
      3'b010: begin
        // R3
        neg_chk: assert (result == WIDTH'(-opA)) else $error("neg mismatch");
      end
      3'b011: begin
        // R4
        inc_chk: assert (result == WIDTH'(opA + 1'b1)) else $error("inc mismatch");
      end
      3'b100: begin
        // R5
        and_chk: assert (result == (opA & opB)) else $error("and mismatch");
      end
      3'b101: begin
        // R6
        or_chk: assert (result == (opA | opB)) else $error("or mismatch");
      end
      3'b110: begin
        // R7
        xor_chk: assert (result == (opA ^ opB)) else $error("xor mismatch");
      end
      default: begin
        // R8
        nota_chk: assert (result == ~opA) else $error("not mismatch");
      end
    endcase
  end

endmodule

bind split_alu split_alu_chk #(.WIDTH(WIDTH)) uChk (
  .opA   (opA),
  .opB   (opB),
  .opCode(opCode),
  .result(result)
);

// File: tb/tb_split_alu.sv
`timescale 1ns/1ps
module tb_split_alu;

  localparam int WW = 8;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [WW-1:0] aW, bW, rW;
  logic [NW-1:0] aN, bN, rN;
  logic [2:0]    opW, opN;

  split_alu #(.WIDTH(WW)) dut (
    .opA(aW), .opB(bW), .opCode(opW), .result(rW)
  );

  split_alu #(.WIDTH(NW)) dutNarrow (
    .opA(aN), .opB(bN), .opCode(opN), .result(rN)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] exp;
  } item_t;

  item_t wideQ[$];
  item_t narrowQ[$];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Behavioural reference, derived from the requirement list.
  function automatic logic [7:0] refAlu(input logic [2:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input int w);
    logic [8:0] full;
    logic [7:0] mask;
    mask = 8'((9'd1 << w) - 9'd1);
    case (op)
      3'd0: full = {1'b0, a} + {1'b0, b};
      3'd1: full = {1'b0, a} - {1'b0, b};
      3'd2: full = 9'd0 - {1'b0, a};
      3'd3: full = {1'b0, a} + 9'd1;
      3'd4: full = {1'b0, a & b};
      3'd5: full = {1'b0, a | b};
      3'd6: full = {1'b0, a ^ b};
      default: full = {1'b0, ~a};
    endcase
    return full[7:0] & mask;
  endfunction

  function automatic string reqFor(input item_t it, input int w);
    string s;
    case (it.op)
      3'd0: s = "R1";
      3'd1: s = "R2";
      3'd2: s = "R3";
      3'd3: s = "R4";
      3'd4: s = "R5";
      3'd5: s = "R6";
      3'd6: s = "R7";
      default: s = "R8";
    endcase
    if (it.op == 3'd0 && (int'(it.a) + int'(it.b)) >= (1 << w)) s = {s, " R9"};
    return {s, " R10"};
  endfunction

  task automatic driveWide(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    item_t it;
    @(posedge clk);
    #1;
    opW = op; aW = a; bW = b;
    it.op = op; it.a = a; it.b = b; it.exp = refAlu(op, a, b, WW);
    wideQ.push_back(it);
  endtask

  task automatic driveNarrow(input logic [2:0] op, input logic [3:0] a, input logic [3:0] b);
    item_t it;
    @(posedge clk);
    #1;
    opN = op; aN = a; bN = b;
    it.op = op; it.a = {4'd0, a}; it.b = {4'd0, b}; it.exp = refAlu(op, {4'd0, a}, {4'd0, b}, NW);
    narrowQ.push_back(it);
  endtask

  // Monitors: compare in the middle of each cycle.
  always @(negedge clk) begin
    if (!rst && wideQ.size() > 0) begin
      item_t it;
      it = wideQ.pop_front();
      checks++;
      if (rW !== it.exp) begin
        errors++;
        $display("FAIL %s w%0d op=%0d a=%h b=%h actual=%h expected=%h",
                 reqFor(it, WW), WW, it.op, it.a, it.b, rW, it.exp);
      end
    end
    if (!rst && narrowQ.size() > 0) begin
      item_t it;
      it = narrowQ.pop_front();
      checks++;
      if ({4'd0, rN} !== it.exp) begin
        errors++;
        $display("FAIL %s w%0d op=%0d a=%h b=%h actual=%h expected=%h",
                 reqFor(it, NW), NW, it.op, it.a, it.b, rN, it.exp);
      end
    end
  end

  logic [7:0] corners [5] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01};

  initial begin
    opW = '0; aW = '0; bW = '0;
    opN = '0; aN = '0; bN = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // Reset-state style check: all-zero inputs give zero (R1).
    @(negedge clk);
    checks++;
    if (rW !== 8'h00) begin
      errors++;
      $display("FAIL R1 idle actual=%h expected=00", rW);
    end

    // Corner operands in every pairing, every opcode.
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          driveWide(3'(op), corners[i], corners[j]);

    // Carry out of the top bit is dropped (R9).
    driveWide(3'd0, 8'hFF, 8'h01);
    driveWide(3'd0, 8'hFF, 8'hFF);
    driveWide(3'd3, 8'hFF, 8'h00);
    driveWide(3'd0, 8'h80, 8'h80);

    // opB has no effect for R3, R4, R8: same opA, different opB.
    for (int k = 0; k < 16; k++) begin
      logic [7:0] a;
      a = 8'($urandom);
      driveWide(3'd2, a, 8'($urandom));
      driveWide(3'd2, a, 8'($urandom));
      driveWide(3'd3, a, 8'($urandom));
      driveWide(3'd3, a, 8'($urandom));
      driveWide(3'd7, a, 8'($urandom));
      driveWide(3'd7, a, 8'($urandom));
    end

    // Random operands on all opcodes (R1..R8, R10).
    for (int k = 0; k < 1200; k++)
      driveWide(3'($urandom), 8'($urandom), 8'($urandom));

    // Exhaustive sweep on the 4-bit copy.
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          driveNarrow(3'(op), 4'(a), 4'(b));

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule